// File: doc/BRIEF.md
# Delayed-Transfer Fetch Sequencer with Slot Cancellation

This block produces the fetch address for a four-stage pipeline: fetch with decode and operand read, then execute, then memory access, then register write-back. A branch or call computes its destination only in the execute stage. By then the next sequential instruction has already been fetched. The sequencer therefore delays every control transfer by one instruction. The instruction that follows a transfer, called the slot instruction, is always fetched. Fetching switches to the destination only after that instruction.

The execute stage describes the instruction it holds on four inputs: a transfer kind, the evaluated condition, a cancel request and the destination address. The sequencer keeps a current and a next address for fetch, plus the address of the instruction now in execute. If a conditional transfer carries the cancel request and is not taken, the slot instruction is turned into a no-op. The squash output marks it while it sits in execute, so it writes no register, changes no flag and does not reach memory. A call also produces a link write that carries its own address.

Transfer kind encoding on `xfer_kind_i`: 0 = none, 1 = conditional, 2 = always, 3 = never, 4 = call.

Top module: `dbs_pc_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_addr_o` is 0, `squash_o` is 0, `link_we_o` is 0 and `ex_pc_o` is 0. After reset the execute stage is empty, so transfer inputs in the first cycle have no effect.
- R2: When no transfer is redirecting fetch, `fetch_addr_o` grows by 4 every cycle, wrapping modulo 2^ADDR_W.
- R3: A conditional transfer (kind 1) with `xfer_taken_i`=1 that is in execute while its slot instruction is fetched makes `fetch_addr_o` equal the destination in the next cycle. Exactly one slot instruction is fetched between the transfer and its destination.
- R4: A conditional transfer with `xfer_taken_i`=0 and no cancel request falls through: fetch continues sequentially and `squash_o` stays 0.
- R5: A conditional transfer with `xfer_annul_i`=1 and `xfer_taken_i`=0 raises `squash_o` for exactly the one cycle its slot instruction is in execute. When the same transfer is taken, `squash_o` stays 0.
- R6: Kind 3 (never) never redirects, whatever `xfer_taken_i` says. Combined with `xfer_annul_i`=1 it squashes its slot instruction.
- R7: Kind 2 (always) redirects whatever `xfer_taken_i` says, and its cancel request has no effect.
- R8: A call (kind 4) redirects like a taken transfer and ignores its cancel request. One cycle later it raises `link_we_o` for one cycle, with `link_addr_o` equal to the call's own address.
- R9: Transfer inputs are ignored while the instruction in execute is squashed: no redirect and no link write.
- R10: A transfer placed in the slot of a taken transfer takes effect in turn. Exactly one instruction at the first destination is fetched before fetch moves to the second destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_kind_i | input | 3 | Transfer kind of the instruction in execute |
| xfer_taken_i | input | 1 | Evaluated condition for a conditional transfer |
| xfer_annul_i | input | 1 | Cancel request for the slot instruction |
| xfer_target_i | input | ADDR_W | Destination address computed in execute |
| fetch_addr_o | output | ADDR_W | Address fetched this cycle |
| ex_pc_o | output | ADDR_W | Address of the instruction in execute |
| squash_o | output | 1 | Instruction in execute is cancelled |
| link_we_o | output | 1 | Link register write strobe |
| link_addr_o | output | ADDR_W | Value written to the link register |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 4-byte instruction step and a reset address of 0. With these values each expected fetch address is an exact constant, and a jump to the top word of the address space brings the wrap of the sequential step within reach. It also covers a call whose own address is that top word. The stimulus runs every transfer kind with both condition values and both cancel settings. It also places a transfer back to back in a slot, and places a call inside a squashed slot and inside the empty execute stage after reset.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        XK_NONE   = 3'd0,
        XK_COND   = 3'd1,
        XK_ALWAYS = 3'd2,
        XK_NEVER  = 3'd3,
        XK_CALL   = 3'd4
    } xfer_kind_e;

endpackage

// File: rtl/dbs_xfer_decide.sv
module dbs_xfer_decide
    import dbs_pkg::*;
(
    input  xfer_kind_e kind_i,
    input  logic       taken_i,
    input  logic       annul_i,
    input  logic       live_i,
    output logic       redirect_o,
    output logic       kill_slot_o,
    output logic       link_req_o
);

    logic eff_taken;
    logic cancellable;

    always_comb begin
        eff_taken   = 1'b0;
        cancellable = 1'b0;
        unique case (kind_i)
            XK_COND: begin
                eff_taken   = taken_i;
                cancellable = 1'b1;
            end
            XK_ALWAYS: eff_taken = 1'b1;
            XK_NEVER: begin
                eff_taken   = 1'b0;
                cancellable = 1'b1;
            end
            XK_CALL:   eff_taken = 1'b1;
            default:   eff_taken = 1'b0;
        endcase
    end

    // The slot instruction survives a cancel request only when the branch goes.
    assign redirect_o  = live_i & eff_taken;
    assign kill_slot_o = live_i & cancellable & annul_i & ~eff_taken;
    assign link_req_o  = live_i & (kind_i == XK_CALL);

endmodule

// File: rtl/dbs_addr_step.sv
module dbs_addr_step #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    assign addr_o = addr_i + STEP;

endmodule

// File: rtl/dbs_pc_seq.sv
module dbs_pc_seq
    import dbs_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        xfer_kind_i,
    input  logic              xfer_taken_i,
    input  logic              xfer_annul_i,
    input  logic [ADDR_W-1:0] xfer_target_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [ADDR_W-1:0] ex_pc_o,
    output logic              squash_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_addr_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        logic [ADDR_W-1:0] ex_pc;
        logic              ex_valid;
        logic              squash;
        logic              link_we;
        logic [ADDR_W-1:0] link_addr;
    } seq_t;

    seq_t st_d, st_q;

    xfer_kind_e        kind;
    logic              ex_live;
    logic              redirect;
    logic              kill_slot;
    logic              link_req;
    logic [ADDR_W-1:0] sel_pc;
    logic [ADDR_W-1:0] sel_pc_next;

    assign kind    = xfer_kind_e'(xfer_kind_i);
    assign ex_live = st_q.ex_valid & ~st_q.squash;

    dbs_xfer_decide u_decide (
        .kind_i      (kind),
        .taken_i     (xfer_taken_i),
        .annul_i     (xfer_annul_i),
        .live_i      (ex_live),
        .redirect_o  (redirect),
        .kill_slot_o (kill_slot),
        .link_req_o  (link_req)
    );

    assign sel_pc = redirect ? xfer_target_i : st_q.npc;

    dbs_addr_step #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_step (
        .addr_i (sel_pc),
        .addr_o (sel_pc_next)
    );

    always_comb begin
        st_d           = st_q;
        st_d.pc        = sel_pc;
        st_d.npc       = sel_pc_next;
        st_d.ex_pc     = st_q.pc;
        st_d.ex_valid  = 1'b1;
        st_d.squash    = kill_slot;
        st_d.link_we   = link_req;
        st_d.link_addr = st_q.ex_pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc        <= RESET_PC;
            st_q.npc       <= RESET_PC + STEP;
            st_q.ex_pc     <= '0;
            st_q.ex_valid  <= 1'b0;
            st_q.squash    <= 1'b0;
            st_q.link_we   <= 1'b0;
            st_q.link_addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr_o = st_q.pc;
    assign ex_pc_o      = st_q.ex_pc;
    assign squash_o     = st_q.squash;
    assign link_we_o    = st_q.link_we;
    assign link_addr_o  = st_q.link_addr;

endmodule

// File: rtl/dbs_pc_seq_chk.sv
module dbs_pc_seq_chk
    import dbs_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        kind,
    input logic              taken,
    input logic              annul,
    input logic [ADDR_W-1:0] target,
    input logic [ADDR_W-1:0] fetch,
    input logic              squash,
    input logic              link_we,
    input logic [ADDR_W-1:0] link_addr,
    input logic              ex_live
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch == '0 && !squash && !link_we));

    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XK_NONE) |=> (fetch == $past(fetch) + STEP));

    a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == XK_COND && !taken) || kind == XK_NEVER) |=> (fetch == $past(fetch) + STEP));

    a_r3_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_live && ((kind == XK_COND && taken) || kind == XK_ALWAYS || kind == XK_CALL))
        |=> (fetch == $past(target)));

    a_r5_squash_single: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !squash);

    a_r5_squash_cause: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> $past(annul));

    a_r8_link_addr: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_addr == $past(fetch, 2)));

    a_r9_dead_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_live |=> (fetch == $past(fetch) + STEP && !link_we));

endmodule

bind dbs_pc_seq dbs_pc_seq_chk #(
    .ADDR_W      (ADDR_W),
    .INSTR_BYTES (INSTR_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (xfer_kind_i),
    .taken     (xfer_taken_i),
    .annul     (xfer_annul_i),
    .target    (xfer_target_i),
    .fetch     (fetch_addr_o),
    .squash    (squash_o),
    .link_we   (link_we_o),
    .link_addr (link_addr_o),
    .ex_live   (ex_live)
);

// File: tb/dbs_pc_seq_tb.sv
module dbs_pc_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  kind = 3'd0;
    logic        taken = 1'b0;
    logic        annul = 1'b0;
    logic [31:0] target = '0;
    logic [31:0] fetch_addr;
    logic [31:0] ex_pc;
    logic        squash;
    logic        link_we;
    logic [31:0] link_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] fetch;
        logic [31:0] ex;
        logic        sq;
        logic        lwe;
        logic [31:0] laddr;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbs_pc_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_kind_i   (kind),
        .xfer_taken_i  (taken),
        .xfer_annul_i  (annul),
        .xfer_target_i (target),
        .fetch_addr_o  (fetch_addr),
        .ex_pc_o       (ex_pc),
        .squash_o      (squash),
        .link_we_o     (link_we),
        .link_addr_o   (link_addr)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: apply the execute-stage view for the coming edge and queue the outcome.
    task automatic drive(input logic [2:0] k, input logic t, input logic a, input logic [31:0] tgt,
                         input logic [31:0] e_fetch, input logic [31:0] e_ex, input logic e_sq,
                         input logic e_lwe, input logic [31:0] e_laddr, input string req);
        exp_t it;
        kind = k; taken = t; annul = a; target = tgt;
        it.fetch = e_fetch; it.ex = e_ex; it.sq = e_sq; it.lwe = e_lwe; it.laddr = e_laddr; it.req = req;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compare registered outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check(it.req, "fetch", fetch_addr, it.fetch);
                check(it.req, "ex_pc", ex_pc, it.ex);
                check(it.req, "squash", {31'd0, squash}, {31'd0, it.sq});
                check(it.req, "link_we", {31'd0, link_we}, {31'd0, it.lwe});
                if (it.lwe) check(it.req, "link_addr", link_addr, it.laddr);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "fetch", fetch_addr, 32'h0);
        check("R1", "squash", {31'd0, squash}, 32'd0);
        check("R1", "link_we", {31'd0, link_we}, 32'd0);
        check("R1", "ex_pc", ex_pc, 32'h0);
        rst_n = 1'b1;
        //    kind  tk  an  target         fetch          ex_pc          sq  lwe laddr
        drive(3'd4, 0, 0, 32'h100,      32'h4,        32'h0,        0, 0, 0, "R1");
        drive(3'd0, 0, 0, 32'h0,        32'h8,        32'h4,        0, 0, 0, "R2");
        drive(3'd0, 0, 0, 32'h0,        32'hC,        32'h8,        0, 0, 0, "R2");
        drive(3'd1, 1, 0, 32'h40,       32'h40,       32'hC,        0, 0, 0, "R3");
        drive(3'd0, 0, 0, 32'h0,        32'h44,       32'h40,       0, 0, 0, "R3");
        drive(3'd0, 0, 0, 32'h0,        32'h48,       32'h44,       0, 0, 0, "R2");
        drive(3'd1, 0, 0, 32'h200,      32'h4C,       32'h48,       0, 0, 0, "R4");
        drive(3'd0, 0, 0, 32'h0,        32'h50,       32'h4C,       0, 0, 0, "R4");
        drive(3'd1, 0, 1, 32'h300,      32'h54,       32'h50,       1, 0, 0, "R5");
        drive(3'd4, 0, 0, 32'h500,      32'h58,       32'h54,       0, 0, 0, "R9");
        drive(3'd1, 1, 1, 32'h80,       32'h80,       32'h58,       0, 0, 0, "R5");
        drive(3'd0, 0, 0, 32'h0,        32'h84,       32'h80,       0, 0, 0, "R5");
        drive(3'd3, 1, 0, 32'h900,      32'h88,       32'h84,       0, 0, 0, "R6");
        drive(3'd3, 0, 1, 32'h900,      32'h8C,       32'h88,       1, 0, 0, "R6");
        drive(3'd0, 0, 0, 32'h0,        32'h90,       32'h8C,       0, 0, 0, "R6");
        drive(3'd2, 0, 1, 32'hA0,       32'hA0,       32'h90,       0, 0, 0, "R7");
        drive(3'd0, 0, 0, 32'h0,        32'hA4,       32'hA0,       0, 0, 0, "R7");
        drive(3'd4, 0, 1, 32'h1000,     32'h1000,     32'hA4,       0, 1, 32'hA0, "R8");
        drive(3'd0, 0, 0, 32'h0,        32'h1004,     32'h1000,     0, 0, 0, "R8");
        drive(3'd2, 1, 0, 32'h2000,     32'h2000,     32'h1004,     0, 0, 0, "R10");
        drive(3'd2, 1, 0, 32'h3000,     32'h3000,     32'h2000,     0, 0, 0, "R10");
        drive(3'd0, 0, 0, 32'h0,        32'h3004,     32'h3000,     0, 0, 0, "R10");
        drive(3'd1, 1, 0, 32'hFFFFFFFC, 32'hFFFFFFFC, 32'h3004,     0, 0, 0, "R3");
        drive(3'd0, 0, 0, 32'h0,        32'h0,        32'hFFFFFFFC, 0, 0, 0, "R2");
        drive(3'd4, 0, 0, 32'h10,       32'h10,       32'h0,        0, 1, 32'hFFFFFFFC, "R8");
        drive(3'd0, 0, 0, 32'h0,        32'h14,       32'h10,       0, 0, 0, "R8");
        @(negedge clk);
        @(negedge clk);
        // R1 reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "fetch", fetch_addr, 32'h0);
        check("R1", "squash", {31'd0, squash}, 32'd0);
        check("R1", "link_we", {31'd0, link_we}, 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule